// File: doc/BRIEF.md
# Chained-Descriptor Block Copy Engine

This block is one memory-to-memory copy channel that walks a chain of block descriptors without help from software. Software writes the first block's source pointer, destination pointer, link pointer and control word straight into the channel, then sets the start bit. The engine copies the block one word at a time: it reads a word from the source and then writes it to the destination. When the block is finished it follows the link pointer. It fetches the next four-word descriptor from memory, reloads its working registers and copies that block too.

A link pointer of zero marks the final block. After that block the channel goes idle and pulses its done output for one cycle. A bus error response on any access stops the channel and raises a sticky error flag. All traffic goes through a single request/acknowledge master port, and that port has only one access outstanding at a time.

Top module: `sgdma_chain_engine`

## Requirements
- R1: After reset, `busy`, `done`, `err_flag` and `mem_req` are all low.
- R2: Configuration selects are: 0 source pointer, 1 destination pointer, 2 link pointer, 3 control word, 4 start (bit 0 of the data). These writes take effect only while the channel is idle. A start write sets `busy` in the next cycle and clears `err_flag`. The first access is then a data read from the programmed source pointer, not a descriptor fetch.
- R3: Control bits [11:0] give the block length in words. Each word is one read (`mem_we`=0) from the source followed by one write (`mem_we`=1) to the destination of the data just read. After each word the source pointer advances by 4 if control bit 26 is set, and the destination pointer advances by 4 if control bit 27 is set. A pointer whose bit is clear stays fixed.
- R4: When a block ends and the link pointer is nonzero, the engine makes four reads at link+0x0, +0x4, +0x8 and +0xC. These words become source, destination, link and control. The working registers change only after the fourth word arrives, and copying of the new block starts afterwards.
- R5: When a block ends with a zero link pointer, no fetch is made. In the cycle after the last write is acknowledged, `busy` drops and `done` is high for exactly one cycle.
- R6: A block whose length field is zero makes no data access. The chain moves straight on to the fetch, or to completion.
- R7: An error response on any access ends the channel. `busy` drops, `err_flag` rises and stays high until the next start, no further request is made and `done` does not pulse. A write that gets an error response is not counted as done.
- R8: The two low bits of the link pointer are ignored when descriptor fetch addresses are formed.
- R9: Once `mem_req` is raised, it and `mem_addr`, `mem_we` and `mem_wdata` hold steady until `mem_ack` or `mem_err` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed with a bus error |
| busy | output | 1 | Channel enabled and working |
| done | output | 1 | One-cycle pulse at normal chain end |
| err_flag | output | 1 | Sticky bus error indication |

## Verification
Each access completes on the clock edge that samples `mem_ack`. The next request is therefore visible in the cycle straight after that edge, and `done` together with the fall of `busy` also appear in the cycle after the final write's acknowledge. `busy` rises, and `err_flag` clears, one cycle after the start write. The bench drives its memory responder and samples every output on the falling edge. It compares each acknowledged access against a behavioural queue of expected transactions built from the descriptors, and so checks the result in exactly the cycle in which the access is due. The done pulse is counted on every falling edge. The responder's latency is varied between zero and two wait cycles, so the checks do not depend on a fixed handshake delay.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
    localparam int WORD_W      = 32;
    localparam int LEN_W       = 12;
    localparam int SRC_INC_BIT = 26;
    localparam int DST_INC_BIT = 27;
    localparam int DESC_WORDS  = 4;
    localparam int IDX_W       = $clog2(DESC_WORDS);
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int SEL_W       = 3;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_SRC  = 3'd0,
        SEL_DST  = 3'd1,
        SEL_LINK = 3'd2,
        SEL_CTRL = 3'd3,
        SEL_GO   = 3'd4
    } sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_READ,
        ST_WRITE,
        ST_FETCH
    } state_e;

    typedef struct packed {
        word_t src;
        word_t dst;
        word_t link;
        word_t ctrl;
    } desc_t;

    function automatic logic [LEN_W-1:0] blk_len(input word_t c);
        return c[LEN_W-1:0];
    endfunction

    function automatic word_t align_word(input word_t a);
        return {a[WORD_W-1:2], 2'b00};
    endfunction
endpackage

// File: rtl/sgdma_ptr.sv
module sgdma_ptr #(
    parameter int W    = 32,
    parameter int STEP = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] ptr
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= load_val;
        else if (step) ptr <= ptr + STEP_V;
    end
endmodule

// File: rtl/sgdma_desc_collect.sv
module sgdma_desc_collect
    import sgdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic [IDX_W-1:0] idx,
    input  word_t            word,
    output desc_t            desc
);
    word_t slot [DESC_WORDS-1];

    for (genvar i = 0; i < DESC_WORDS - 1; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                      slot[i] <= '0;
            else if (cap && idx == IDX_W'(i)) slot[i] <= word;
        end
    end

    always_comb begin
        desc.src  = slot[0];
        desc.dst  = slot[1];
        desc.link = slot[2];
        desc.ctrl = word;
    end
endmodule

// File: rtl/sgdma_chain_engine.sv
module sgdma_chain_engine
    import sgdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [31:0]      cfg_wdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ack,
    input  logic             mem_err,
    output logic             busy,
    output logic             done,
    output logic             err_flag
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    state_e           st;
    logic [IDX_W-1:0] fidx;
    word_t            link_q, ctrl_q, data_q;
    logic [LEN_W-1:0] remain;
    word_t            src_ptr, dst_ptr;
    desc_t            fdesc;

    logic idle_wr, fetch_last, wr_ack;
    assign idle_wr    = cfg_we && (st == ST_IDLE);
    assign fetch_last = (st == ST_FETCH) && mem_ack && (fidx == LAST_IDX);
    assign wr_ack     = (st == ST_WRITE) && mem_ack;

    sgdma_desc_collect u_collect (
        .clk  (clk),
        .rst  (rst),
        .cap  ((st == ST_FETCH) && mem_ack),
        .idx  (fidx),
        .word (mem_rdata),
        .desc (fdesc)
    );

    sgdma_ptr #(.W(WORD_W), .STEP(WORD_BYTES)) u_src (
        .clk      (clk),
        .rst      (rst),
        .load     ((idle_wr && cfg_sel == SEL_SRC) || fetch_last),
        .load_val (fetch_last ? fdesc.src : cfg_wdata),
        .step     (wr_ack && ctrl_q[SRC_INC_BIT]),
        .ptr      (src_ptr)
    );

    sgdma_ptr #(.W(WORD_W), .STEP(WORD_BYTES)) u_dst (
        .clk      (clk),
        .rst      (rst),
        .load     ((idle_wr && cfg_sel == SEL_DST) || fetch_last),
        .load_val (fetch_last ? fdesc.dst : cfg_wdata),
        .step     (wr_ack && ctrl_q[DST_INC_BIT]),
        .ptr      (dst_ptr)
    );

    // Memory port is a pure function of state so it stays put until answered.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st)
            ST_READ:  begin mem_req = 1'b1; mem_addr = src_ptr; end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_ptr;
                mem_wdata = data_q;
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = align_word(link_q) + {28'd0, fidx, 2'b00};
            end
            default: ;
        endcase
    end

    assign busy = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            fidx     <= '0;
            link_q   <= '0;
            ctrl_q   <= '0;
            data_q   <= '0;
            remain   <= '0;
            done     <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (cfg_we) begin
                        if (cfg_sel == SEL_LINK) link_q <= cfg_wdata;
                        if (cfg_sel == SEL_CTRL) ctrl_q <= cfg_wdata;
                        if (cfg_sel == SEL_GO && cfg_wdata[0]) begin
                            st       <= ST_START;
                            err_flag <= 1'b0;
                        end
                    end
                end
                ST_START: begin
                    remain <= blk_len(ctrl_q);
                    if (blk_len(ctrl_q) != '0) begin
                        st <= ST_READ;
                    end else if (link_q == '0) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end else begin
                        st   <= ST_FETCH;
                        fidx <= '0;
                    end
                end
                ST_READ: begin
                    if (mem_err) begin
                        st       <= ST_IDLE;
                        err_flag <= 1'b1;
                    end else if (mem_ack) begin
                        data_q <= mem_rdata;
                        st     <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_err) begin
                        st       <= ST_IDLE;
                        err_flag <= 1'b1;
                    end else if (mem_ack) begin
                        remain <= remain - 1'b1;
                        if (remain != LEN_W'(1)) begin
                            st <= ST_READ;
                        end else if (link_q == '0) begin
                            st   <= ST_IDLE;
                            done <= 1'b1;
                        end else begin
                            st   <= ST_FETCH;
                            fidx <= '0;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_err) begin
                        st       <= ST_IDLE;
                        err_flag <= 1'b1;
                    end else if (mem_ack) begin
                        if (fidx == LAST_IDX) begin
                            link_q <= fdesc.link;
                            ctrl_q <= fdesc.ctrl;
                            st     <= ST_START;
                        end else begin
                            fidx <= fidx + 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sgdma_chain_checker.sv
module sgdma_chain_checker (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        mem_err,
    input logic        busy,
    input logic        done,
    input logic        err_flag
);
    a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !mem_err) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !err_flag));

    a_r7_err_idle: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> !busy);

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);
endmodule

bind sgdma_chain_engine sgdma_chain_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .busy      (busy),
    .done      (done),
    .err_flag  (err_flag)
);

// File: tb/test_sgdma_chain_engine.sv
module test_sgdma_chain_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        mem_req, mem_we, busy, done, err_flag;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;

    always #10 clk = ~clk;

    sgdma_chain_engine i_sgdma_chain_engine (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .busy(busy), .done(done),
        .err_flag(err_flag)
    );

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [31:0] data;
    } xact_t;

    xact_t       exp_q[$];
    logic [31:0] mem [logic [31:0]];
    logic [31:0] err_addr = 32'hFFFF_FFF0;
    bit          expect_err;
    int          vectors = 0;
    int          fails = 0;
    int          done_cnt = 0;
    int          wait_cnt = 0;
    int          lat = 0;
    int          cycles = 0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit push(input bit we, input logic [31:0] a,
                                input logic [31:0] d);
        xact_t x;
        x.we = we; x.addr = a; x.data = d;
        exp_q.push_back(x);
        if (a == err_addr) begin
            expect_err = 1'b1;
            return 1'b1;
        end
        return 1'b0;
    endfunction

    // Behavioural expectation of the whole chain's bus traffic (R2-R8).
    task automatic build_expect(input logic [31:0] s0, input logic [31:0] d0,
                                input logic [31:0] n0, input logic [31:0] c0);
        logic [31:0] s = s0, d = d0, n = n0, c = c0, a;
        bit stop = 1'b0;
        expect_err = 1'b0;
        forever begin
            for (int i = 0; i < int'(c[11:0]) && !stop; i++) begin
                stop = push(1'b0, s, 32'h0);
                if (!stop) stop = push(1'b1, d, rd(s));
                if (c[26]) s += 4;
                if (c[27]) d += 4;
            end
            if (stop || n == 32'h0) break;
            a = {n[31:2], 2'b00};
            for (int k = 0; k < 4 && !stop; k++) stop = push(1'b0, a + 4 * k, 32'h0);
            if (stop) break;
            s = rd(a); d = rd(a + 4); n = rd(a + 8); c = rd(a + 12);
        end
    endtask

    // Memory responder and per-cycle comparison, all on the falling edge.
    always @(negedge clk) begin
        if (rst) begin
            mem_ack  <= 1'b0;
            mem_err  <= 1'b0;
            wait_cnt = 0;
        end else begin
            if (done) begin
                done_cnt++;
                chk(!busy, "R5 busy low with done", {31'd0, busy}, 32'd0);
            end
            if (mem_req && wait_cnt >= lat) begin
                wait_cnt = 0;
                lat = (lat + 1) % 3;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected access", mem_addr, 32'hFFFF_FFFF);
                    mem_ack <= 1'b1;
                    mem_err <= 1'b0;
                end else begin
                    xact_t x;
                    x = exp_q.pop_front();
                    chk(mem_we == x.we, "R3 access direction", {31'd0, mem_we}, {31'd0, x.we});
                    chk(mem_addr == x.addr, "R4 access address", mem_addr, x.addr);
                    if (x.we) chk(mem_wdata == x.data, "R3 write data", mem_wdata, x.data);
                    if (mem_addr == err_addr) begin
                        mem_ack <= 1'b0;
                        mem_err <= 1'b1;
                    end else begin
                        mem_ack <= 1'b1;
                        mem_err <= 1'b0;
                        if (mem_we) mem[mem_addr] = mem_wdata;
                        else mem_rdata <= rd(mem_addr);
                    end
                end
            end else begin
                if (mem_req) wait_cnt++;
                mem_ack <= 1'b0;
                mem_err <= 1'b0;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic cfg(input logic [2:0] sel, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] s,
                            input logic [31:0] d, input logic [31:0] n,
                            input logic [31:0] c);
        mem[a] = s; mem[a + 4] = d; mem[a + 8] = n; mem[a + 12] = c;
    endtask

    task automatic fill(input logic [31:0] base, input int n, input logic [31:0] seed);
        for (int i = 0; i < n; i++) mem[base + 4 * i] = seed ^ (32'h1111_0000 * i) ^ i;
    endtask

    task automatic run(input logic [31:0] s, input logic [31:0] d,
                       input logic [31:0] n, input logic [31:0] c, input string tag);
        build_expect(s, d, n, c);
        done_cnt = 0;
        cfg(3'd0, s); cfg(3'd1, d); cfg(3'd2, n); cfg(3'd3, c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = 32'h1;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", {31'd0, busy}, 32'd1);
        chk(err_flag == 1'b0, "R7 error cleared by start", {31'd0, err_flag}, 32'd0);
        for (int t = 0; t < 4000 && busy; t++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " all accesses seen"}, exp_q.size(), 32'd0);
        chk(err_flag == expect_err, {tag, " R7 error flag"}, {31'd0, err_flag}, {31'd0, expect_err});
        chk(done_cnt == (expect_err ? 0 : 1), {tag, " R5 done pulses"}, done_cnt, expect_err ? 0 : 1);
        chk(!busy && !mem_req, {tag, " R7 channel quiet"}, {30'd0, busy, mem_req}, 32'd0);
        exp_q.delete();
    endtask

    localparam logic [31:0] INC_S = 32'h0400_0000;
    localparam logic [31:0] INC_D = 32'h0800_0000;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !err_flag && !mem_req, "R1 reset state",
            {28'd0, busy, done, err_flag, mem_req}, 32'd0);

        fill(32'h0000_0100, 16, 32'hA5A5_0000);
        fill(32'h0000_0140, 16, 32'h5A5A_1000);
        fill(32'h0000_0180, 16, 32'h3C3C_2000);
        fill(32'h0000_01C0, 16, 32'hC3C3_3000);

        // R3 R5: single block, both pointers increment.
        run(32'h100, 32'h2000, 32'h0, INC_S | INC_D | 32'd3, "R3 single");

        // R4 R6 R8: three-block chain, unaligned link, zero-length middle, fixed source.
        put_desc(32'h3000, 32'h140, 32'h2100, 32'h3010, INC_S | INC_D);
        put_desc(32'h3010, 32'h180, 32'h2200, 32'h0, INC_D | 32'd3);
        run(32'h100, 32'h2000, 32'h3002, INC_S | INC_D | 32'd2, "R4 R6 R8 chain");

        // R6 R3: first block empty, then source increments into a fixed destination.
        put_desc(32'h3100, 32'h1C0, 32'h2300, 32'h0, INC_S | 32'd2);
        run(32'h100, 32'h2000, 32'h3100, INC_S | INC_D, "R6 R3 empty first");

        // R7: error response on a data write in the middle of a block.
        err_addr = 32'h2404;
        run(32'h100, 32'h2400, 32'h0, INC_S | INC_D | 32'd4, "R7 write error");

        // R7: error response on the third word of a descriptor fetch.
        err_addr = 32'h3208;
        put_desc(32'h3200, 32'h140, 32'h2500, 32'h0, INC_S | INC_D | 32'd1);
        run(32'h180, 32'h2480, 32'h3200, INC_S | INC_D | 32'd1, "R7 fetch error");

        // R2 R7: restart after an error clears the flag and completes normally.
        err_addr = 32'hFFFF_FFF0;
        run(32'h1C0, 32'h2600, 32'h3200, INC_S | INC_D | 32'd2, "R2 restart");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule